// File: doc/BRIEF.md
# Two-Wire Dock Status Link

This block drives the docking-station end of a two-wire serial link to an expansion audio unit. One output wire is both the shift clock and the frame marker. The other wire is a shared data line that the block drives for part of each frame and listens on for the rest. Each frame starts with a sync gap, in which the clock wire stays high for several bit periods with no edges. A download period follows, in which a parallel payload goes out serially. One silent turnaround bit comes next, and then an upload period in which the remote unit returns its button and joystick switch states. The remote can also append a received MIDI byte.

The bit rate is the system clock divided by `2*HALF_DIV`. Each bit period has a low half followed by a high half. Data changes on the falling edge and is sampled on the rising edge. Frames repeat back to back for as long as the docked input stays high. With the default sizes a frame is 35 bits long, which at a 3.58 MHz bit rate is about 10 µs. That is well inside a 140 µs mirroring budget. When the docked input drops, the link stops at once and every status output holds its value.

Top module: `dock_link`

## Requirements
- R1: Each frame begins with the link clock held high, with no edges, for at least `SYNC_BITS` bit periods. The first falling edge after that starts download bit 0.
- R2: Every bit period lasts `2*HALF_DIV` system clocks. In each period the link clock is low for `HALF_DIV` clocks, then high for `HALF_DIV` clocks.
- R3: During download the block sends `DL_BITS` payload bits, most significant bit first. The payload is captured at the end of the sync gap. Each bit changes on a falling edge and is stable at the following rising edge.
- R4: The data driver enable is high throughout the download bits and low at every other time. It drops at the falling edge of a single turnaround bit that comes before the upload bits.
- R5: The upload period has 16 bits, each sampled at a rising edge. The first 8 bits received form status byte S, and the next 8 bits form byte M. Each byte is sent MSB first.
- R6: When a frame completes, `joy_sw_o` takes S[3:0], `vol_up_o` takes S[4], `vol_dn_o` takes S[5] and `mute_o` takes S[6].
- R7: If S[7] is 1, `midi_data_o` takes M and `midi_valid_o` is high for exactly one system clock.
- R8: If S[7] is 0, M is discarded: `midi_data_o` keeps its value and no strobe occurs.
- R9: While the docked input is low, the link clock is high, the driver enable is low, the status and MIDI outputs hold, and no strobe occurs. A frame in progress when the docked input drops is abandoned and updates nothing.
- R10: During and after reset the link clock is high, the driver enable and data are low, all status outputs are 0 and the MIDI strobe is low.
- R11: While docked, frames follow one another without a gap. A payload presented during the upload period of one frame is sent in the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| docked_i | input | 1 | High while the expansion unit is attached |
| dl_payload_i | input | DL_BITS | Parallel word to send in the download period |
| link_clk_o | output | 1 | Link shift clock and frame marker |
| link_data_o | output | 1 | Serial data driven toward the remote unit |
| link_data_oe_o | output | 1 | Enable for the shared data line driver |
| link_data_i | input | 1 | Serial data from the remote unit (asynchronous) |
| joy_sw_o | output | 4 | Joystick switch states |
| vol_up_o | output | 1 | Volume-up button state |
| vol_dn_o | output | 1 | Volume-down button state |
| mute_o | output | 1 | Mute button state |
| midi_data_o | output | 8 | Last MIDI byte received |
| midi_valid_o | output | 1 | One-clock strobe for a new MIDI byte |

## Verification
The three link outputs come from one register stage, so the clock, data and enable all move on the same system clock, one cycle after the internal state changes. The bench samples download data at each observed rising edge and checks the enable at each observed falling edge. The remote's data goes through a two-flop synchroniser and is taken on the last clock of each bit period. The bench therefore drives a new upload bit as soon as it sees a falling edge. The status and MIDI results appear `HALF_DIV-1` clocks after the last rising edge of the upload. The bench waits one full bit period plus two clocks before checking them, which is still inside the next sync gap, and it counts strobes on every falling system-clock edge.

// File: rtl/dock_link_pkg.sv
package dock_link_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_SYNC = 3'd1,
    PH_DOWN = 3'd2,
    PH_TURN = 3'd3,
    PH_UP   = 3'd4
  } phase_t;

  localparam int UP_BITS = 16;
endpackage

// File: rtl/dock_link_timer.sv
module dock_link_timer #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic low_half_o,
  output logic bit_end_o
);
  localparam int PER = 2 * HALF_DIV;
  localparam int CW  = $clog2(PER);

  logic [CW-1:0] cnt_q, cnt_d;

  assign low_half_o = cnt_q < CW'(HALF_DIV);
  assign bit_end_o  = run_i && (cnt_q == CW'(PER - 1));

  always_comb begin
    if (!run_i || bit_end_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: a bit period always restarts from the first clock of the low half
  assert_period_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bit_end_o |=> low_half_o);
endmodule

// File: rtl/dock_link_seq.sv
module dock_link_seq
  import dock_link_pkg::*;
#(
  parameter int SYNC_BITS = 2,
  parameter int DL_BITS   = 16
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   docked_i,
  input  logic   bit_end_i,
  output phase_t phase_o,
  output logic   last_bit_o
);
  localparam int MAXB = (SYNC_BITS > DL_BITS) ?
                        ((SYNC_BITS > UP_BITS) ? SYNC_BITS : UP_BITS) :
                        ((DL_BITS > UP_BITS) ? DL_BITS : UP_BITS);
  localparam int BCW = $clog2(MAXB + 1);

  phase_t         ph_q, ph_d;
  logic [BCW-1:0] bc_q, bc_d;
  int             len;

  always_comb begin
    case (ph_q)
      PH_SYNC: len = SYNC_BITS;
      PH_DOWN: len = DL_BITS;
      PH_UP:   len = UP_BITS;
      default: len = 1;
    endcase
  end

  assign last_bit_o = bit_end_i && (int'(bc_q) == len - 1);
  assign phase_o    = ph_q;

  always_comb begin
    ph_d = ph_q;
    bc_d = bc_q;
    if (!docked_i) begin
      ph_d = PH_IDLE;
      bc_d = '0;
    end else if (ph_q == PH_IDLE) begin
      ph_d = PH_SYNC;
      bc_d = '0;
    end else if (last_bit_o) begin
      bc_d = '0;
      case (ph_q)
        PH_SYNC: ph_d = PH_DOWN;
        PH_DOWN: ph_d = PH_TURN;
        PH_TURN: ph_d = PH_UP;
        default: ph_d = PH_SYNC;
      endcase
    end else if (bit_end_i) begin
      bc_d = bc_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= PH_IDLE;
      bc_q <= '0;
    end else begin
      ph_q <= ph_d;
      bc_q <= bc_d;
    end
  end

  // R4: the turnaround lasts exactly one bit and is followed by upload
  assert_turn_one_bit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_TURN && bit_end_i && docked_i) |=> (ph_q == PH_UP));
endmodule

// File: rtl/dock_link_tx.sv
module dock_link_tx #(
  parameter int DL_BITS = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               shift_i,
  input  logic [DL_BITS-1:0] payload_i,
  output logic               msb_o
);
  logic [DL_BITS-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       sh_q <= '0;
    else if (load_i)  sh_q <= payload_i;
    else if (shift_i) sh_q <= {sh_q[DL_BITS-2:0], 1'b0};
  end

  assign msb_o = sh_q[DL_BITS-1];

  // R3: the first bit sent is the payload MSB seen at capture time
  assert_load_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (msb_o == $past(payload_i[DL_BITS-1])));
endmodule

// File: rtl/dock_link_rx.sv
module dock_link_rx
  import dock_link_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din_i,
  input  logic       sample_i,
  input  logic       done_i,
  input  logic       upd_en_i,
  output logic [6:0] status_o,
  output logic [7:0] midi_data_o,
  output logic       midi_vld_o
);
  logic                 s1_q, s2_q;
  logic [UP_BITS-2:0]   sh_q;
  logic [UP_BITS-1:0]   word;
  logic                 take;

  assign word = {sh_q, s2_q};
  assign take = done_i && upd_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= din_i;
      s2_q <= s1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sh_q <= '0;
    else if (sample_i) sh_q <= word[UP_BITS-2:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o    <= '0;
      midi_data_o <= '0;
      midi_vld_o  <= 1'b0;
    end else begin
      midi_vld_o <= take && word[UP_BITS-1];
      if (take) status_o <= word[UP_BITS-2 -: 7];
      if (take && word[UP_BITS-1]) midi_data_o <= word[7:0];
    end
  end

  // R7: the MIDI strobe never lasts more than one clock
  assert_midi_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    midi_vld_o |=> !midi_vld_o);
  // R8: the MIDI byte changes only together with its strobe
  assert_midi_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(midi_data_o) |-> midi_vld_o);
endmodule

// File: rtl/dock_link.sv
module dock_link
  import dock_link_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int SYNC_BITS = 2,
  parameter int DL_BITS   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               docked_i,
  input  logic [DL_BITS-1:0] dl_payload_i,
  output logic               link_clk_o,
  output logic               link_data_o,
  output logic               link_data_oe_o,
  input  logic               link_data_i,
  output logic [3:0]         joy_sw_o,
  output logic               vol_up_o,
  output logic               vol_dn_o,
  output logic               mute_o,
  output logic [7:0]         midi_data_o,
  output logic               midi_valid_o
);
  phase_t     phase;
  logic       run, low_half, bit_end, last_bit, tx_msb;
  logic       clk_d, oe_d, sd_d, toggling;
  logic [6:0] status;

  assign run = (phase != PH_IDLE);

  dock_link_timer #(.HALF_DIV(HALF_DIV)) u_timer (
    .clk(clk), .rst_n(rst_n), .run_i(run),
    .low_half_o(low_half), .bit_end_o(bit_end)
  );

  dock_link_seq #(.SYNC_BITS(SYNC_BITS), .DL_BITS(DL_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .docked_i(docked_i), .bit_end_i(bit_end),
    .phase_o(phase), .last_bit_o(last_bit)
  );

  dock_link_tx #(.DL_BITS(DL_BITS)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .load_i(last_bit && phase == PH_SYNC),
    .shift_i(bit_end && phase == PH_DOWN),
    .payload_i(dl_payload_i), .msb_o(tx_msb)
  );

  dock_link_rx u_rx (
    .clk(clk), .rst_n(rst_n), .din_i(link_data_i),
    .sample_i(bit_end && phase == PH_UP),
    .done_i(last_bit && phase == PH_UP),
    .upd_en_i(docked_i),
    .status_o(status), .midi_data_o(midi_data_o), .midi_vld_o(midi_valid_o)
  );

  assign joy_sw_o = status[3:0];
  assign vol_up_o = status[4];
  assign vol_dn_o = status[5];
  assign mute_o   = status[6];

  always_comb begin
    toggling = (phase == PH_DOWN) || (phase == PH_TURN) || (phase == PH_UP);
    clk_d    = !(toggling && low_half);
    oe_d     = (phase == PH_DOWN);
    sd_d     = oe_d && tx_msb;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_clk_o     <= 1'b1;
      link_data_oe_o <= 1'b0;
      link_data_o    <= 1'b0;
    end else begin
      link_clk_o     <= clk_d;
      link_data_oe_o <= oe_d;
      link_data_o    <= sd_d;
    end
  end

  // R4: driving begins exactly on the first download falling edge
  assert_oe_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_data_oe_o) |-> $fell(link_clk_o));
  // R4: release happens on the turnaround falling edge
  assert_oe_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(link_data_oe_o) && $past(docked_i, 2)) |-> $fell(link_clk_o));
  // R9: undocked link is parked high and undriven
  assert_undock_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(docked_i) |=> (link_clk_o && !link_data_oe_o));
  // R9: status is frozen while undocked
  assert_undock_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !docked_i |=> $stable({mute_o, vol_dn_o, vol_up_o, joy_sw_o}));
endmodule

// File: tb/dock_link_tb.sv
module dock_link_tb;
  localparam int HALF = 4;
  localparam int SYNC = 2;
  localparam int DL   = 16;
  localparam int PER  = 2 * HALF;
  localparam int LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          docked_i = 1'b0;
  logic [DL-1:0] dl_payload_i = '0;
  logic          link_data_i = 1'b0;
  logic          link_clk_o, link_data_o, link_data_oe_o;
  logic [3:0]    joy_sw_o;
  logic          vol_up_o, vol_dn_o, mute_o;
  logic [7:0]    midi_data_o;
  logic          midi_valid_o;

  always #4 clk = ~clk;

  dock_link #(.HALF_DIV(HALF), .SYNC_BITS(SYNC), .DL_BITS(DL)) u_dut (
    .clk(clk), .rst_n(rst_n), .docked_i(docked_i), .dl_payload_i(dl_payload_i),
    .link_clk_o(link_clk_o), .link_data_o(link_data_o),
    .link_data_oe_o(link_data_oe_o), .link_data_i(link_data_i),
    .joy_sw_o(joy_sw_o), .vol_up_o(vol_up_o), .vol_dn_o(vol_dn_o),
    .mute_o(mute_o), .midi_data_o(midi_data_o), .midi_valid_o(midi_valid_o)
  );

  int   checks = 0, errors = 0, cyc = 0;
  bit   tmo = 0;
  logic prev_s = 1'b1, cur_s = 1'b1;
  int   hi_run = 0, lo_run = 0, last_hi = 0, last_lo = 0;
  int   vld_cnt = 0;
  logic [7:0] last_midi = '0;
  logic [7:0] exp_midi = '0;

  always @(negedge clk) if (midi_valid_o) begin
    vld_cnt++;
    last_midi = midi_data_o;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (cyc > LIMIT) tmo = 1;
    prev_s = cur_s;
    cur_s  = link_clk_o;
    if (cur_s) begin
      if (!prev_s) begin last_lo = lo_run; lo_run = 0; end
      hi_run++;
    end else begin
      if (prev_s) begin last_hi = hi_run; hi_run = 0; end
      lo_run++;
    end
  endtask

  task automatic wait_fall();
    do tick(); while (!(prev_s && !cur_s) && !tmo);
  endtask

  task automatic wait_rise();
    do tick(); while (!(!prev_s && cur_s) && !tmo);
  endtask

  function automatic logic [DL-1:0] pay(input int k);
    return DL'(k * 40503 + 4660);
  endfunction

  task automatic run_frame(input logic [7:0] b0, input logic [7:0] b1,
                           input logic [DL-1:0] exp_dl, input logic [DL-1:0] nxt);
    int v0;
    logic [15:0] up;
    up = {b0, b1};
    wait_fall();
    chk(last_hi >= SYNC * PER, "R1 sync gap", last_hi, SYNC * PER);
    for (int i = 0; i < DL; i++) begin
      if (i > 0) begin
        wait_fall();
        chk(last_hi == HALF, "R2 high half", last_hi, HALF);
      end
      chk(link_data_oe_o == 1'b1, "R4 enable in download", link_data_oe_o, 1);
      wait_rise();
      chk(last_lo == HALF, "R2 low half", last_lo, HALF);
      chk(link_data_o == exp_dl[DL-1-i], "R3 download bit", link_data_o, exp_dl[DL-1-i]);
    end
    wait_fall();
    chk(link_data_oe_o == 1'b0, "R4 released at turnaround", link_data_oe_o, 0);
    wait_rise();
    v0 = vld_cnt;
    for (int j = 0; j < 16; j++) begin
      wait_fall();
      link_data_i = up[15-j];
      if (j == 0) dl_payload_i = nxt;
      chk(link_data_oe_o == 1'b0, "R5 line free in upload", link_data_oe_o, 0);
      wait_rise();
    end
    repeat (PER + 2) tick();
    chk({mute_o, vol_dn_o, vol_up_o, joy_sw_o} == b0[6:0], "R6 status bits",
        {mute_o, vol_dn_o, vol_up_o, joy_sw_o}, b0[6:0]);
    if (b0[7]) begin
      exp_midi = b1;
      chk(vld_cnt == v0 + 1, "R7 one strobe", vld_cnt - v0, 1);
      chk(last_midi == b1, "R7 midi byte", last_midi, b1);
    end else begin
      chk(vld_cnt == v0, "R8 no strobe", vld_cnt - v0, 0);
    end
    chk(midi_data_o == exp_midi, "R8 midi data held or updated", midi_data_o, exp_midi);
  endtask

  initial begin
    logic [6:0] st_keep;
    int v_keep, bad;
    repeat (3) tick();
    chk(link_clk_o == 1'b1 && link_data_oe_o == 1'b0 && link_data_o == 1'b0,
        "R10 link idle in reset", {link_clk_o, link_data_oe_o, link_data_o}, 3'b100);
    rst_n = 1'b1;
    repeat (4) tick();
    chk({mute_o, vol_dn_o, vol_up_o, joy_sw_o} == 7'd0, "R10 status zero",
        {mute_o, vol_dn_o, vol_up_o, joy_sw_o}, 0);
    chk(midi_data_o == 8'd0 && midi_valid_o == 1'b0, "R10 midi zero",
        {midi_valid_o, midi_data_o}, 0);
    chk(link_clk_o == 1'b1, "R9 undocked clock high", link_clk_o, 1);

    dl_payload_i = pay(0);
    docked_i = 1'b1;
    // R11: back-to-back frames, exhaustive over the status byte
    for (int k = 0; k < 256 && !tmo; k++)
      run_frame(8'(k), 8'(k * 29 + 11), pay(k), pay(k + 1));

    // R9: abandon a frame part-way through download
    wait_fall();
    wait_rise();
    wait_rise();
    docked_i = 1'b0;
    st_keep = {mute_o, vol_dn_o, vol_up_o, joy_sw_o};
    v_keep = vld_cnt;
    repeat (3) tick();
    bad = 0;
    for (int t = 0; t < 20 * PER; t++) begin
      link_data_i = t[2];
      tick();
      if (link_clk_o !== 1'b1 || link_data_oe_o !== 1'b0) bad++;
    end
    chk(bad == 0, "R9 link parked while undocked", bad, 0);
    chk(vld_cnt == v_keep, "R9 no strobe while undocked", vld_cnt - v_keep, 0);
    chk({mute_o, vol_dn_o, vol_up_o, joy_sw_o} == st_keep, "R9 status held",
        {mute_o, vol_dn_o, vol_up_o, joy_sw_o}, st_keep);
    chk(midi_data_o == exp_midi, "R9 midi held", midi_data_o, exp_midi);

    docked_i = 1'b1;
    run_frame(8'hD2, 8'h3C, pay(256), pay(300));
    run_frame(8'h15, 8'hFF, pay(300), pay(301));
    run_frame(8'hFF, 8'h00, pay(301), pay(302));

    if (tmo) chk(1'b0, "R11 watchdog expired", cyc, LIMIT);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule